// File: doc/BRIEF.md
# Capture Input Conditioner

This block prepares one timer capture input before capture events are produced from it. The raw pin level first goes through a two-flop synchronizer. A digital filter then accepts a new level only after enough equal samples in a row. A single 4-bit filter code sets both the sample rate and the number of samples needed. The sample rate is either the timer clock or a divided version of a dead-time clock enable.

An edge detector picks rising or falling edges of the filtered level. An edge prescaler then passes only every 1st, 2nd, 4th or 8th qualified edge. Each passed edge becomes a one-cycle capture strobe for the counter latch that follows the block. When the channel is disabled, the prescaler is cleared and no strobe is produced.

Top module: `icap_conditioner`

## Requirements
- R1: The pin passes through two synchronizer flops. With filter code 0, a pin change made before rising clock edge A produces its capture strobe high just after the fourth rising edge, counting A as the first.
- R2: After reset release, the filtered level starts at the synchronized pin level. Whatever level the pin holds at start-up, it never causes a capture strobe.
- R3: Filter code 0 applies no filtering. The filtered level copies the synchronized input on every clock.
- R4: Codes 1, 2 and 3 sample on every timer clock. They need 2, 4 and 8 equal samples in a row before the filtered level changes.
- R5: Codes 4/5 sample every 2nd dead-time tick, codes 6/7 every 4th and codes 8/9 every 8th. The even code of each pair needs 6 equal samples and the odd code needs 8.
- R6: Codes 10, 11 and 12 sample every 16th dead-time tick. Codes 13, 14 and 15 sample every 32nd tick. Within each group the codes need 5, 6 and 8 samples in that order.
- R7: A sample that equals the current filtered level clears the run count. A glitch shorter than the required run therefore has no effect, and the next run starts from zero.
- R8: The sample divider counts dead-time ticks and takes a sample on every Nth tick. A change of filter code restarts both the divider and the run count.
- R9: With the edge select at 0, rising edges of the filtered level are qualified. With it at 1, falling edges are qualified.
- R10: Prescale code 0, 1, 2 or 3 produces a strobe on every 1st, 2nd, 4th or 8th qualified edge. The count starts after the last clear.
- R11: While the channel enable is low, the edge prescaler is held at zero and no strobe is produced.
- R12: Each capture strobe lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dts_tick | input | 1 | One-cycle enable marking each dead-time clock period |
| pin_in | input | 1 | Raw capture pin, asynchronous |
| flt_sel | input | 4 | Filter code: selects sample rate and run length |
| psc_sel | input | 2 | Edge prescale code |
| fall_sel | input | 1 | 0 qualifies rising edges, 1 qualifies falling edges |
| ch_en | input | 1 | Channel enable; low clears the prescaler |
| cap_pulse | output | 1 | One-cycle capture strobe |

## Verification
A wrong run count or a wrong divider phase moves the capture strobe by whole sample periods. With the slowest codes this can be hundreds of cycles. Comparing against the reference on every clock catches it on the first strobe that should or should not have appeared. A prescaler that is not cleared shows up as a strobe on the wrong edge of the next burst, within one to eight edges. Missing start-up seeding shows up as a spurious strobe a few cycles after reset.

// File: rtl/icap_conditioner.sv
module icap_conditioner #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dts_tick,
  input  logic       pin_in,
  input  logic [3:0] flt_sel,
  input  logic [1:0] psc_sel,
  input  logic       fall_sel,
  input  logic       ch_en,
  output logic       cap_pulse
);
  localparam int WARM_LAST = SYNC_STAGES + 1;
  localparam int WARM_W    = $clog2(WARM_LAST + 1);

  function automatic logic [3:0] run_need(input logic [3:0] c);
    case (c)
      4'd1:                        return 4'd2;
      4'd2:                        return 4'd4;
      4'd10, 4'd13:                return 4'd5;
      4'd4, 4'd6, 4'd8, 4'd11, 4'd14: return 4'd6;
      default:                     return 4'd8;
    endcase
  endfunction

  function automatic logic [2:0] div_log2(input logic [3:0] c);
    case (c)
      4'd4, 4'd5:          return 3'd1;
      4'd6, 4'd7:          return 3'd2;
      4'd8, 4'd9:          return 3'd3;
      4'd10, 4'd11, 4'd12: return 3'd4;
      4'd13, 4'd14, 4'd15: return 3'd5;
      default:             return 3'd0;
    endcase
  endfunction

  logic [SYNC_STAGES-1:0] sync_q;
  logic [WARM_W-1:0]      warm_q;
  logic [DIV_W-1:0]       div_q;
  logic [3:0]             flt_q;
  logic [3:0]             run_q;
  logic [2:0]             psc_q;
  logic                   filt_q, filt_d;

  wire             s_in      = sync_q[SYNC_STAGES-1];
  wire             warm_done = (warm_q == WARM_LAST[WARM_W-1:0]);
  wire             code_chg  = (flt_sel != flt_q);
  wire [3:0]       need      = run_need(flt_sel);
  wire [DIV_W-1:0] div_mask  = DIV_W'((1 << div_log2(flt_sel)) - 1);
  wire             clk_rate  = (flt_sel != 4'd0) && (flt_sel < 4'd4);
  wire             samp      = !code_chg &&
                               (clk_rate || (flt_sel >= 4'd4 && dts_tick &&
                                             ((div_q & div_mask) == div_mask)));
  wire [2:0]       psc_mask  = (3'd1 << psc_sel) - 3'd1;
  wire             edge_q    = warm_done && (filt_q != filt_d) && (filt_q == !fall_sel);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          warm_q <= '0;
    else if (!warm_done) warm_q <= warm_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_q <= '0;
      div_q <= '0;
    end else begin
      flt_q <= flt_sel;
      if (code_chg)      div_q <= '0;
      else if (dts_tick) div_q <= div_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      filt_q <= 1'b0;
      filt_d <= 1'b0;
      run_q  <= '0;
    end else if (!warm_done) begin
      filt_q <= s_in;
      filt_d <= s_in;
      run_q  <= '0;
    end else begin
      filt_d <= filt_q;
      if (flt_sel == 4'd0) begin
        filt_q <= s_in;
        run_q  <= '0;
      end else if (code_chg) begin
        run_q <= '0;
      end else if (samp) begin
        if (s_in == filt_q) run_q <= '0;
        else if (run_q == need - 4'd1) begin
          filt_q <= s_in;
          run_q  <= '0;
        end else run_q <= run_q + 4'd1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      psc_q     <= '0;
      cap_pulse <= 1'b0;
    end else begin
      cap_pulse <= ch_en && edge_q && (psc_q == psc_mask);
      if (!ch_en) psc_q <= '0;
      else if (edge_q) psc_q <= (psc_q == psc_mask) ? 3'd0 : psc_q + 3'd1;
    end
endmodule

module icap_conditioner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ch_en,
  input logic       cap_pulse,
  input logic       warm_done,
  input logic [3:0] flt_sel,
  input logic [3:0] flt_q,
  input logic [3:0] run_q,
  input logic [3:0] need,
  input logic       samp,
  input logic       s_in,
  input logic       filt_q,
  input logic [2:0] psc_q
);
  p_one_wide_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> !cap_pulse);
  p_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |=> !cap_pulse);
  p_psc_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |=> (psc_q == 3'd0));
  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_done && flt_sel == 4'd0) |=> (filt_q == $past(s_in)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_done && flt_sel != 4'd0 && !samp) |=> $stable(filt_q));
  p_run_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_done && flt_sel != 4'd0 && flt_sel == flt_q) |-> (run_q < need));
endmodule

bind icap_conditioner icap_conditioner_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .cap_pulse(cap_pulse),
  .warm_done(warm_done), .flt_sel(flt_sel), .flt_q(flt_q), .run_q(run_q),
  .need(need), .samp(samp), .s_in(s_in), .filt_q(filt_q), .psc_q(psc_q));

// File: tb/icap_conditioner_tb.sv
`timescale 1ns/1ps
module icap_conditioner_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dts_tick = 1'b0, pin_in = 1'b1, fall_sel = 1'b0, ch_en = 1'b1;
  logic [3:0] flt_sel = 4'd0;
  logic [1:0] psc_sel = 2'd0;
  logic cap_pulse;

  always #4 clk = ~clk;

  icap_conditioner dut_i (.clk(clk), .rst_n(rst_n), .dts_tick(dts_tick), .pin_in(pin_in),
    .flt_sel(flt_sel), .psc_sel(psc_sel), .fall_sel(fall_sel), .ch_en(ch_en),
    .cap_pulse(cap_pulse));

  int checks = 0, fails = 0, pulses = 0, tick_every = 1, tick_cnt = 0;
  bit done = 0;
  string cur_req = "R2";

  // behavioural reference
  int m_s1, m_s2, m_filt, m_prev, m_run, m_ticks, m_psc, m_warm, m_code;
  bit m_cap;

  function automatic int need_of(int c);
    int t[16] = '{0, 2, 4, 8, 6, 8, 6, 8, 6, 8, 5, 6, 8, 5, 6, 8};
    return t[c];
  endfunction
  function automatic int rate_of(int c);
    if (c < 4) return 1;
    if (c < 6) return 2;
    if (c < 8) return 4;
    if (c < 10) return 8;
    if (c < 13) return 16;
    return 32;
  endfunction

  always @(posedge clk) begin
    int o_s2, o_filt, o_prev, code;
    bit smp, edg;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_filt = 0; m_prev = 0; m_run = 0; m_ticks = 0;
      m_psc = 0; m_warm = 0; m_code = 0; m_cap = 0;
    end else begin
      o_s2 = m_s2; o_filt = m_filt; o_prev = m_prev; code = int'(flt_sel);
      edg = (m_warm >= 3) && (o_filt != o_prev) && (o_filt == (fall_sel ? 0 : 1));
      smp = (code == m_code) && ((code >= 1 && code <= 3) ||
            (code >= 4 && dts_tick && ((m_ticks + 1) % rate_of(code) == 0)));
      m_cap = 0;
      if (!ch_en) m_psc = 0;
      else if (edg) begin
        if (m_psc == (1 << psc_sel) - 1) begin m_cap = 1; m_psc = 0; end
        else m_psc++;
      end
      if (m_warm < 3) begin
        m_filt = o_s2; m_prev = o_s2; m_run = 0; m_warm++;
      end else begin
        m_prev = o_filt;
        if (code == 0) begin m_filt = o_s2; m_run = 0; end
        else if (code != m_code) m_run = 0;
        else if (smp) begin
          if (o_s2 == o_filt) m_run = 0;
          else if (m_run + 1 == need_of(code)) begin m_filt = o_s2; m_run = 0; end
          else m_run++;
        end
      end
      if (code != m_code) m_ticks = 0; else if (dts_tick) m_ticks++;
      m_code = code; m_s2 = m_s1; m_s1 = int'(pin_in);
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check({cur_req, " cycle compare"}, int'(cap_pulse), int'(m_cap));
    if (cap_pulse) pulses++;
  end

  task automatic cyc(int n);
    repeat (n) begin
      @(negedge clk);
      tick_cnt++;
      dts_tick = (tick_cnt % tick_every) == 0;
    end
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) begin
      pin_in = 1; cyc(3); pin_in = 0; cyc(3);
    end
  endtask

  initial begin
    int p0;
    // R2: pin high through reset, no strobe at start-up
    cyc(5);
    check("R2 reset strobe", int'(cap_pulse), 0);
    rst_n = 1;
    cyc(12);
    check("R2 start-up pulses", pulses, 0);

    // R1 / R3 / R12: pass-through latency and width
    cur_req = "R1"; pin_in = 0; cyc(10);
    pin_in = 1;
    for (int k = 1; k <= 6; k++) begin
      cyc(1);
      check(k == 5 ? "R12 width" : "R1 latency", int'(cap_pulse), k == 4 ? 1 : 0);
    end
    pin_in = 0; cyc(4);
    cur_req = "R3"; p0 = pulses; edges(3); cyc(6);
    check("R3 pass-through", pulses - p0, 3);

    // R4: timer-clock sampling
    cur_req = "R4"; flt_sel = 4'd2; cyc(20);
    p0 = pulses; pin_in = 1; cyc(3); pin_in = 0; cyc(20);
    check("R4 code2 short", pulses - p0, 0);
    pin_in = 1; cyc(4); pin_in = 0; cyc(1); cyc(20);
    check("R4 code2 run of 4", pulses - p0, 1);
    flt_sel = 4'd1; cyc(10); p0 = pulses;
    pin_in = 1; cyc(1); pin_in = 0; cyc(10);
    check("R4 code1 glitch", pulses - p0, 0);
    pin_in = 1; cyc(2); pin_in = 0; cyc(10);
    check("R4 code1 run of 2", pulses - p0, 1);

    // R7: interrupted run restarts
    cur_req = "R7"; flt_sel = 4'd3; cyc(20); p0 = pulses;
    pin_in = 1; cyc(5); pin_in = 0; cyc(1); pin_in = 1; cyc(5); pin_in = 0; cyc(20);
    check("R7 interrupted run", pulses - p0, 0);
    pin_in = 1; cyc(8); pin_in = 0; cyc(20);
    check("R7 full run", pulses - p0, 1);

    // R5 / R6: divided dead-time sampling for every slow code
    for (int c = 4; c <= 15; c++) begin
      cur_req = (c < 10) ? "R5" : "R6";
      tick_every = (c < 10) ? 1 : 3;
      flt_sel = 4'(c); pin_in = 0; cyc(1100); p0 = pulses;
      pin_in = 1; cyc(1100); pin_in = 0; cyc(1100);
      check({cur_req, " slow code capture"}, pulses - p0, 1);
    end
    tick_every = 1;
    cur_req = "R5"; flt_sel = 4'd5; cyc(100); p0 = pulses;
    pin_in = 1; cyc(12); pin_in = 0; cyc(100);
    check("R5 code5 short", pulses - p0, 0);
    cur_req = "R6"; flt_sel = 4'd13; cyc(400); p0 = pulses;
    pin_in = 1; cyc(100); pin_in = 0; cyc(400);
    check("R6 code13 short", pulses - p0, 0);

    // R8: code change restarts divider and run
    cur_req = "R8"; flt_sel = 4'd15; cyc(300); p0 = pulses;
    pin_in = 1; cyc(200); flt_sel = 4'd14; cyc(150);
    check("R8 restart on code change", pulses - p0, 0);
    cyc(100);
    check("R8 capture after restart", pulses - p0, 1);
    pin_in = 0; cyc(300);

    // R9: falling edge selection
    cur_req = "R9"; flt_sel = 4'd0; fall_sel = 1; cyc(10); p0 = pulses;
    pin_in = 1; cyc(10);
    check("R9 rise ignored", pulses - p0, 0);
    pin_in = 0; cyc(10);
    check("R9 fall captured", pulses - p0, 1);
    fall_sel = 0; cyc(5);

    // R10: prescale ratios
    cur_req = "R10";
    for (int p = 0; p < 4; p++) begin
      psc_sel = 2'(p); ch_en = 0; cyc(2); ch_en = 1; p0 = pulses;
      edges(16); cyc(10);
      check("R10 prescale count", pulses - p0, 16 >> p);
    end

    // R11: disable clears prescaler and blocks strobes
    cur_req = "R11"; psc_sel = 2'd2; ch_en = 0; cyc(2); ch_en = 1; p0 = pulses;
    edges(3); ch_en = 0; cyc(2); ch_en = 1; edges(3); cyc(6);
    check("R11 cleared by disable", pulses - p0, 0);
    edges(1); cyc(6);
    check("R11 fourth edge after clear", pulses - p0, 1);
    ch_en = 0; p0 = pulses; edges(8); cyc(6);
    check("R11 no strobe while disabled", pulses - p0, 0);
    ch_en = 1; cyc(5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule